// File: doc/BRIEF.md
# Receive Descriptor Status Writeback Engine

This block sits between a MAC receive path and software. It keeps a small ring of receive descriptors in registers. Each entry has an ownership bit, a programmable buffer length, a byte count and a 32-bit status word. The receive side reports one data byte per cycle, then an end-of-frame strobe that carries the frame's completion flags. The engine assigns the bytes to buffers. It spreads a frame over as many ring entries as it needs, and when it finishes with an entry it closes it with a status word. That word carries chaining marks, error flags, an address-match flag and the count of bytes placed in that buffer. Ownership then returns to software.

Software hands an empty buffer back by writing its index and length on the give port. It reads any entry through a combinational read port. A one-cycle interrupt flags each released descriptor that ends a frame. A counter records the frames that were lost, in whole or in part, because no buffer was available.

Top module: `rxdesc_wb`

## Requirements
- R1: After reset every descriptor is host-owned with an all-zero status word and zero count; `irq` is 0 and `miss_cnt` is 0. Status bit 23 always reads 0.
- R2: A give to a host-owned entry sets its status word to 0x8000_0000 (bit 31 set = engine owns it), clears its count and stores the given buffer length (at least 1). A give to an entry the engine owns is ignored, and the stored length is kept.
- R3: Status bit 30 (error summary) equals the OR of bits 29 (framing), 28 (overflow), 27 (CRC) and 26 (buffer error).
- R4: Bit 29 is set only in the closing descriptor of a frame that ends with both the FCS-error and dribble flags and without overflow. Dribble alone leaves bits 29 and 30 clear.
- R5: Bit 27 is set in the closing descriptor when the frame ends with an FCS error or a PHY receive error and without overflow. Bits 29, 27 and 22 (address match) appear only in a descriptor whose bit 24 (end of packet) is set.
- R6: An overflow flag at end of frame sets bit 28 and suppresses bits 29 and 27.
- R7: A frame no longer than the current buffer closes one descriptor with bits 25 (start) and 24 (end) set, bit 31 clear and count equal to the frame's byte count.
- R8: When a byte arrives while the current buffer already holds its full length, the engine closes that descriptor with bit 24 clear, bit 25 set only if it is the frame's first buffer, and count equal to the length. The byte then goes into the next entry.
- R9: If that next entry is host-owned, the closed descriptor also gets bits 26 and 30. The rest of the frame is dropped, no interrupt is raised, and `miss_cnt` increments by one.
- R10: If the current entry is host-owned when a frame's first byte arrives, the whole frame is discarded, no descriptor changes, and `miss_cnt` increments by one.
- R11: The ring index advances past each closed descriptor and wraps from RING_DEPTH-1 to 0.
- R12: `irq` is high for exactly the one cycle after the clock edge that closes a descriptor with bit 24 set, and at no other time.
- R13: Give and engine writeback can both take effect at the same edge. The engine judges ownership on the value held before that edge, so an entry given back in the very cycle the engine needs it is not used by that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 1 | One received data byte this cycle |
| rx_eof | input | 1 | End-of-frame strobe, never together with rx_byte |
| rx_fcs_err | input | 1 | FCS error flag, sampled with rx_eof |
| rx_dribble | input | 1 | Length not a whole number of bytes, sampled with rx_eof |
| rx_phy_err | input | 1 | PHY receive error seen in the frame, sampled with rx_eof |
| rx_fifo_ovf | input | 1 | Receive FIFO overflow in the frame, sampled with rx_eof |
| rx_addr_hit | input | 1 | Destination address matched the station address, sampled with rx_eof |
| host_give | input | 1 | Hand a descriptor to the engine |
| host_give_idx | input | IDX_W | Ring index being handed back |
| host_give_len | input | LEN_W | Buffer length for that entry |
| host_rd_idx | input | IDX_W | Ring index to read |
| host_rd_word | output | 32 | Status word of the selected entry |
| host_rd_count | output | LEN_W | Byte count of the selected entry |
| irq | output | 1 | One-cycle end-of-frame release pulse |
| miss_cnt | output | CNT_W | Missed-frame counter |

## Verification
Two functions can fall in the same cycle: the host's give and the engine's own writeback or ownership check. The bench sends a give for a free entry in the same cycle as an end-of-frame closes a different entry, and expects both changes after that edge. It also sends a give for the very entry that a buffer-full byte needs, in that byte's cycle, and expects the frame to take the buffer-error path while the give still lands. A behavioural model updates on every edge and is compared with the outputs each cycle. Direct checks of the status words and counts are made as well.

// File: rtl/rxwb_pkg.sv
// Shared definitions for the receive descriptor writeback engine.
// Bit positions of the status word are fixed because software decodes them.
package rxwb_pkg;

    localparam int unsigned W_OWN  = 31;
    localparam int unsigned W_ERR  = 30;
    localparam int unsigned W_FRAM = 29;
    localparam int unsigned W_OFLO = 28;
    localparam int unsigned W_CRC  = 27;
    localparam int unsigned W_BUFF = 26;
    localparam int unsigned W_STP  = 25;
    localparam int unsigned W_ENP  = 24;
    localparam int unsigned W_PAM  = 22;

    localparam logic [31:0] WORD_GIVEN = 32'h8000_0000;

    // Completion flags delivered with the end-of-frame strobe.
    typedef struct packed {
        logic fcs;
        logic drib;
        logic phy;
        logic ovf;
        logic hit;
    } eof_flags_t;

    // How a descriptor is being closed.
    typedef struct packed {
        logic first;
        logic last;
        logic buff;
    } close_kind_t;

endpackage

// File: rtl/rxwb_status.sv
// Builds the status word of a descriptor being closed.
// Assumes the end-of-frame flags are only meaningful when kind.last is set;
// OWN is always cleared because a closed entry goes back to the host.
module rxwb_status
    import rxwb_pkg::*;
(
    input  close_kind_t kind,
    input  eof_flags_t  flags,
    output logic [31:0] word
);

    logic ovf_q, crc_q, fram_q, pam_q, err_q;

    // Qualify frame-level flags on the last buffer and on overflow.
    always_comb begin
        ovf_q  = kind.last & flags.ovf;
        crc_q  = kind.last & ~flags.ovf & (flags.fcs | flags.phy);
        fram_q = kind.last & ~flags.ovf & flags.fcs & flags.drib;
        pam_q  = kind.last & flags.hit;
        err_q  = ovf_q | crc_q | fram_q | kind.buff;
    end

    // Place each flag at its decoded position.
    always_comb begin
        word         = '0;
        word[W_ERR]  = err_q;
        word[W_FRAM] = fram_q;
        word[W_OFLO] = ovf_q;
        word[W_CRC]  = crc_q;
        word[W_BUFF] = kind.buff;
        word[W_STP]  = kind.first;
        word[W_ENP]  = kind.last;
        word[W_PAM]  = pam_q;
    end

endmodule

// File: rtl/rxwb_ring.sv
// Register array holding the descriptor ring.
// Engine writes go only to entries it owns, and host gives are accepted only
// for host-owned entries, so the two write sources never meet on one entry.
module rxwb_ring
    import rxwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             give,
    input  logic [IDX_W-1:0] give_idx,
    input  logic [LEN_W-1:0] give_len,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_word,
    input  logic [LEN_W-1:0] wr_count,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [LEN_W-1:0] rd_count,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [LEN_W-1:0] lk_len,
    output logic [DEPTH-1:0] own_vec
);

    logic [31:0]      word_r [DEPTH];
    logic [LEN_W-1:0] len_r  [DEPTH];
    logic [LEN_W-1:0] cnt_r  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Per-entry update: engine writeback first, else an accepted give.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_r[g] <= '0;
                len_r[g]  <= '0;
                cnt_r[g]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                word_r[g] <= wr_word;
                cnt_r[g]  <= wr_count;
            end else if (give && give_idx == IDX_W'(g) && !word_r[g][W_OWN]) begin
                word_r[g] <= WORD_GIVEN;
                len_r[g]  <= give_len;
                cnt_r[g]  <= '0;
            end
        end
        assign own_vec[g] = word_r[g][W_OWN];
    end

    // Combinational read and length lookup.
    always_comb begin
        rd_word  = word_r[rd_idx];
        rd_count = cnt_r[rd_idx];
        lk_len   = len_r[lk_idx];
    end

endmodule

// File: rtl/rxwb_track.sv
// Frame tracker: ring pointer, buffer fill count, drop state and miss count.
// Assumes rx_byte and rx_eof are never high together and buffer lengths are
// at least one. Its write command goes straight to the ring at the same edge.
module rxwb_track
    import rxwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 8,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_byte,
    input  logic             rx_eof,
    input  logic [DEPTH-1:0] own_vec,
    input  logic [LEN_W-1:0] cur_len,
    output logic [IDX_W-1:0] cur_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [LEN_W-1:0] wr_count,
    output close_kind_t      kind,
    output logic             irq,
    output logic [CNT_W-1:0] miss_cnt
);

    logic [IDX_W-1:0] cur_r, nxt;
    logic [LEN_W-1:0] fill_r;
    logic             busy_r, drop_r, first_r;
    logic             full, end_close, fill_close;

    // Next ring position with wrap.
    always_comb nxt = (cur_r == IDX_W'(DEPTH - 1)) ? '0 : cur_r + 1'b1;

    // Decide whether this cycle closes the current descriptor.
    always_comb begin
        full       = (fill_r == cur_len);
        end_close  = rx_eof && busy_r && !drop_r;
        fill_close = rx_byte && !rx_eof && busy_r && !drop_r && full;
        wr_en      = end_close | fill_close;
        wr_idx     = cur_r;
        wr_count   = fill_r;
        kind.first = first_r;
        kind.last  = end_close;
        kind.buff  = fill_close && !own_vec[nxt];
    end

    // Frame state, pointer, miss counter and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_r    <= '0;
            fill_r   <= '0;
            busy_r   <= 1'b0;
            drop_r   <= 1'b0;
            first_r  <= 1'b0;
            irq      <= 1'b0;
            miss_cnt <= '0;
        end else begin
            irq <= end_close;
            if (rx_eof) begin
                busy_r <= 1'b0;
                drop_r <= 1'b0;
                if (end_close) cur_r <= nxt;
            end else if (rx_byte) begin
                if (!busy_r) begin
                    busy_r <= 1'b1;
                    if (own_vec[cur_r]) begin
                        fill_r  <= LEN_W'(1);
                        first_r <= 1'b1;
                    end else begin
                        drop_r   <= 1'b1;
                        miss_cnt <= miss_cnt + 1'b1;
                    end
                end else if (!drop_r) begin
                    if (full) begin
                        cur_r   <= nxt;
                        first_r <= 1'b0;
                        if (own_vec[nxt]) begin
                            fill_r <= LEN_W'(1);
                        end else begin
                            drop_r   <= 1'b1;
                            miss_cnt <= miss_cnt + 1'b1;
                        end
                    end else begin
                        fill_r <= fill_r + 1'b1;
                    end
                end
            end
        end
    end

    assign cur_idx = cur_r;

endmodule

// File: rtl/rxdesc_wb.sv
// Top of the receive descriptor status writeback engine.
// Joins the ring storage, frame tracker and status word builder.
module rxdesc_wb
    import rxwb_pkg::*;
#(
    parameter int RING_DEPTH = 4,
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 16,
    localparam int IDX_W     = $clog2(RING_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_byte,
    input  logic             rx_eof,
    input  logic             rx_fcs_err,
    input  logic             rx_dribble,
    input  logic             rx_phy_err,
    input  logic             rx_fifo_ovf,
    input  logic             rx_addr_hit,
    input  logic             host_give,
    input  logic [IDX_W-1:0] host_give_idx,
    input  logic [LEN_W-1:0] host_give_len,
    input  logic [IDX_W-1:0] host_rd_idx,
    output logic [31:0]      host_rd_word,
    output logic [LEN_W-1:0] host_rd_count,
    output logic             irq,
    output logic [CNT_W-1:0] miss_cnt
);

    eof_flags_t       flags;
    close_kind_t      kind;
    logic [31:0]      wr_word;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, cur_idx;
    logic [LEN_W-1:0] wr_count, cur_len;
    logic [RING_DEPTH-1:0] own_vec;

    // Gather the end-of-frame flags.
    always_comb flags = '{fcs: rx_fcs_err, drib: rx_dribble, phy: rx_phy_err,
                          ovf: rx_fifo_ovf, hit: rx_addr_hit};

    rxwb_track #(.DEPTH(RING_DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_track (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_eof(rx_eof),
        .own_vec(own_vec), .cur_len(cur_len), .cur_idx(cur_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_count(wr_count), .kind(kind),
        .irq(irq), .miss_cnt(miss_cnt)
    );

    rxwb_status i_status (.kind(kind), .flags(flags), .word(wr_word));

    rxwb_ring #(.DEPTH(RING_DEPTH), .LEN_W(LEN_W)) i_ring (
        .clk(clk), .rst_n(rst_n), .give(host_give), .give_idx(host_give_idx),
        .give_len(host_give_len), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .wr_count(wr_count), .rd_idx(host_rd_idx),
        .rd_word(host_rd_word), .rd_count(host_rd_count), .lk_idx(cur_idx),
        .lk_len(cur_len), .own_vec(own_vec)
    );

endmodule

// File: rtl/rxdesc_wb_chk.sv
// Property checker for rxdesc_wb, attached through bind.
module rxdesc_wb_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_eof,
    input logic [31:0]      host_rd_word,
    input logic             irq,
    input logic [CNT_W-1:0] miss_cnt
);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_word[23]);

    p_err_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_word[30] == (|host_rd_word[29:26]));

    p_fram_with_crc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_word[29] |-> host_rd_word[27]);

    p_end_only_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_word[24] |-> !(host_rd_word[29] | host_rd_word[27] | host_rd_word[22]));

    p_ovf_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_word[28] |-> !(host_rd_word[29] | host_rd_word[27]));

    p_miss_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt == $past(miss_cnt)) || (miss_cnt == $past(miss_cnt) + 1'b1));

    p_irq_after_eof_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rx_eof));

    p_irq_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

bind rxdesc_wb rxdesc_wb_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .rx_eof(rx_eof), .host_rd_word(host_rd_word),
    .irq(irq), .miss_cnt(miss_cnt)
);

// File: tb/test_rxdesc_wb.sv
`timescale 1ns/1ps
module test_rxdesc_wb;

    localparam int D = 4;
    localparam int LW = 8;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d_byte = 0, d_eof = 0, d_fcs = 0, d_drib = 0, d_phy = 0, d_ovf = 0, d_hit = 0;
    logic d_give = 0;
    logic [1:0] d_gidx = 0, d_ridx = 0;
    logic [LW-1:0] d_glen = 0;
    logic [31:0] rd_word;
    logic [LW-1:0] rd_count;
    logic irq;
    logic [CW-1:0] miss_cnt;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rxdesc_wb #(.RING_DEPTH(D), .LEN_W(LW), .CNT_W(CW)) i_rxdesc_wb (
        .clk(clk), .rst_n(rst_n), .rx_byte(d_byte), .rx_eof(d_eof),
        .rx_fcs_err(d_fcs), .rx_dribble(d_drib), .rx_phy_err(d_phy),
        .rx_fifo_ovf(d_ovf), .rx_addr_hit(d_hit), .host_give(d_give),
        .host_give_idx(d_gidx), .host_give_len(d_glen), .host_rd_idx(d_ridx),
        .host_rd_word(rd_word), .host_rd_count(rd_count), .irq(irq),
        .miss_cnt(miss_cnt)
    );

    // Behavioural reference state.
    bit [31:0] m_word[D];
    int m_len[D], m_cnt[D];
    int m_cur = 0, m_fill = 0, m_miss = 0;
    bit m_busy = 0, m_drop = 0, m_first = 0, m_irq = 0;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] mk(bit first, bit last, bit buff);
        bit [31:0] w = 0;
        bit crc, fram, ofl;
        ofl = last && d_ovf;
        crc = last && !d_ovf && (d_fcs || d_phy);
        fram = last && !d_ovf && d_fcs && d_drib;
        w[25] = first; w[24] = last; w[26] = buff;
        w[28] = ofl; w[27] = crc; w[29] = fram; w[22] = last && d_hit;
        w[30] = ofl || crc || fram || buff;
        return w;
    endfunction

    // Model of one clock edge using pre-edge ownership.
    task automatic model_edge();
        bit own[D];
        int nx;
        foreach (own[i]) own[i] = m_word[i][31];
        nx = (m_cur + 1) % D;
        m_irq = 0;
        if (d_eof) begin
            if (m_busy && !m_drop) begin
                m_word[m_cur] = mk(m_first, 1, 0);
                m_cnt[m_cur] = m_fill;
                m_irq = 1;
                m_cur = nx;
            end
            m_busy = 0; m_drop = 0;
        end else if (d_byte) begin
            if (!m_busy) begin
                m_busy = 1;
                if (own[m_cur]) begin m_fill = 1; m_first = 1; end
                else begin m_drop = 1; m_miss++; end
            end else if (!m_drop) begin
                if (m_fill == m_len[m_cur]) begin
                    m_word[m_cur] = mk(m_first, 0, !own[nx]);
                    m_cnt[m_cur] = m_fill;
                    m_first = 0;
                    if (own[nx]) m_fill = 1;
                    else begin m_drop = 1; m_miss++; end
                    m_cur = nx;
                end else m_fill++;
            end
        end
        if (d_give && !own[d_gidx]) begin
            m_word[d_gidx] = 32'h8000_0000;
            m_len[d_gidx] = d_glen;
            m_cnt[d_gidx] = 0;
        end
    endtask

    // One clock: edge, model update, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("MODEL irq R12", irq, m_irq);
        chk("MODEL miss R9", miss_cnt, m_miss);
        chk("MODEL word R3", rd_word, m_word[d_ridx]);
        chk("MODEL count R7", rd_count, m_cnt[d_ridx]);
        d_byte = 0; d_eof = 0; d_give = 0;
        d_fcs = 0; d_drib = 0; d_phy = 0; d_ovf = 0; d_hit = 0;
        d_ridx = d_ridx + 1'b1;
    endtask

    task automatic give(int idx, int len);
        d_give = 1; d_gidx = 2'(idx); d_glen = LW'(len); tick();
    endtask

    task automatic frame(int n, bit fcs, bit drib, bit phy, bit ovf, bit hit);
        for (int i = 0; i < n; i++) begin d_byte = 1; tick(); end
        d_eof = 1; d_fcs = fcs; d_drib = drib; d_phy = phy; d_ovf = ovf; d_hit = hit;
        tick();
    endtask

    task automatic peek(int idx, string req, bit [31:0] w, int c);
        d_ridx = 2'(idx);
        @(negedge clk);
        chk(req, rd_word, w);
        chk(req, rd_count, c);
        tick();
    endtask

    initial begin
        foreach (m_word[i]) begin m_word[i] = 0; m_len[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 irq", irq, 0);
        chk("R1 miss", miss_cnt, 0);
        for (int i = 0; i < D; i++) begin
            d_ridx = 2'(i); #1; chk("R1 word", rd_word, 0);
        end
        d_ridx = 0;
        tick();
        give(0, 8); give(1, 8); give(2, 4); give(3, 4);
        peek(2, "R2 given", 32'h8000_0000, 0);
        // single buffer with address match
        for (int i = 0; i < 5; i++) begin d_byte = 1; tick(); end
        d_eof = 1; d_hit = 1; tick();
        chk("R12 irq pulse", irq, 1);
        tick();
        chk("R12 irq low", irq, 0);
        peek(0, "R7 single", 32'h0340_0000, 5);
        frame(8, 1, 1, 0, 0, 0);
        peek(1, "R4 framing", 32'h6B00_0000, 8);
        frame(6, 0, 1, 0, 0, 0);
        peek(2, "R8 chain first", 32'h0200_0000, 4);
        peek(3, "R4 dribble alone", 32'h0100_0000, 2);
        frame(3, 0, 0, 0, 0, 0);
        chk("R10 miss", miss_cnt, 1);
        peek(0, "R10 untouched R11", 32'h0340_0000, 5);
        give(0, 3); give(1, 3);
        frame(4, 0, 0, 1, 0, 0);
        peek(0, "R8 first", 32'h0200_0000, 3);
        peek(1, "R5 phy crc", 32'h4900_0000, 1);
        give(2, 8);
        frame(3, 1, 1, 0, 1, 0);
        peek(2, "R6 overflow", 32'h5300_0000, 3);
        give(3, 2);
        frame(5, 0, 0, 0, 0, 0);
        chk("R9 miss", miss_cnt, 2);
        peek(3, "R9 buff", 32'h4600_0000, 2);
        give(0, 5); give(0, 2);
        // eof closing entry 0 while entry 3 is handed back
        for (int i = 0; i < 4; i++) begin d_byte = 1; tick(); end
        d_eof = 1; d_give = 1; d_gidx = 3; d_glen = 6; tick();
        peek(0, "R2 ignored len", 32'h0300_0000, 4);
        peek(3, "R13 give with writeback", 32'h8000_0000, 0);
        give(1, 2);
        d_byte = 1; tick();
        d_byte = 1; tick();
        d_byte = 1; d_give = 1; d_gidx = 2; d_glen = 5; tick();
        d_eof = 1; tick();
        chk("R13 miss", miss_cnt, 3);
        peek(1, "R13 buff", 32'h4600_0000, 2);
        peek(2, "R13 give landed", 32'h8000_0000, 0);
        frame(1, 0, 0, 0, 0, 0);
        peek(2, "R11 continue", 32'h0300_0000, 1);
        repeat (4) tick();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule